// File: doc/BRIEF.md
# Encoder Counter Bus Master

This block drives an 8-bit bidirectional parallel bus that connects to an external four-axis up/down counter device. A single request on the user side turns into a fixed series of bus beats. A beat is one command byte or one data byte. Each beat has a programmable setup gap, during which both strobes stay high, followed by a programmable strobe pulse.

A read request first tells the device to latch the selected axis. It then collects three count bytes, least significant first, and returns the 24-bit count sign-extended to 32 bits. A write request works in three steps. It opens the device's preload register, sends the three bytes of the new count, and then issues a load command so that the preload value moves into the live counter.

Right after reset, the block writes zero into every axis counter on its own, before it accepts any user request.

Top module: `enc_bus_master`

## Requirements
- R1: When no transaction is running, `bus_rd_no` and `bus_wr_no` are 1, `bus_cmd_o` is 0, `bus_addr_o` is 00, `bus_d_oe_o` is 0 and `bus_d_o` is 0x00.
- R2: After reset is released, the block performs a full write sequence with count 0 on axis 0, then axis 1, then axis 2, then axis 3. There is one idle cycle between consecutive axes. `busy_o` stays 1 from reset until the last of these writes ends, and `done_o` does not pulse.
- R3: A read (`req_write_i`=0) issues four beats in this order: a command beat carrying 0x10, then three read beats that collect the count bytes bits 7:0, 15:8 and 23:16.
- R4: `rd_data_o` holds the collected 24-bit count in bits 23:0, and bits 31:24 are copies of bit 23.
- R5: A write (`req_write_i`=1) issues five beats in this order: command 0x08, data `req_data_i`[7:0], data [15:8], data [23:16], command 0x88.
- R6: Every beat lasts GAP_W cycles with both strobes high, followed by STRB_W cycles with its strobe low. A command beat or write-data beat pulls `bus_wr_no` low; a read beat pulls `bus_rd_no` low. `bus_cmd_o` is 1 for the whole length of a command beat. A read beat samples `bus_d_i` in the last cycle of its strobe.
- R7: `bus_d_oe_o` is 1 for the whole length of command beats and write-data beats, and 0 for the whole length of read beats. The bus is therefore released for GAP_W cycles before each read strobe.
- R8: While a transaction runs, `bus_addr_o` equals the requested axis number.
- R9: A request is accepted on a clock edge where `req_i`=1 and `busy_o`=0. Starting with the following cycle, `busy_o` is 1 until the cycle after the last strobe. In that cycle `done_o` is 1 for exactly one cycle, `busy_o` is 0, and after a read `rd_data_o` is already valid.
- R10: A request presented while `busy_o`=1 is dropped. It starts no transaction and changes no counter.
- R11: `bus_rd_no` and `bus_wr_no` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transaction |
| req_write_i | input | 1 | 1 = write count, 0 = read count |
| req_axis_i | input | 2 | Axis number |
| req_data_i | input | 24 | Count to write |
| busy_o | output | 1 | Transaction or startup clear running |
| done_o | output | 1 | One-cycle pulse at the end of a user transaction |
| rd_data_o | output | 32 | Sign-extended count from the last read |
| bus_cmd_o | output | 1 | 1 = command byte, 0 = data byte |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_addr_o | output | 2 | Axis address lines |
| bus_d_o | output | 8 | Data bus, outgoing value |
| bus_d_oe_o | output | 1 | Data bus drive enable |
| bus_d_i | input | 8 | Data bus, incoming value |

## Verification
The bench targets the following faults, and says for each what it would look like:
- Bus contention: a design that keeps driving the data bus into the gap before a read strobe collides with the device, and the bench sees `bus_d_oe_o` high one beat too long.
- Wrong byte order: a swapped byte sequence, or a missing load command after the preload bytes, leaves the device count different from the written value, so the later read-back fails.
- Wrong sign extension: counts 0x800001, 0xFFFFFF and 0x7FFFFF catch a design that extends from the wrong bit or zero-fills.
- Stray request: a request arriving mid-transaction must not restart the sequence or modify another axis.
- Startup clear: reading an axis just after reset must return zero even though the device model starts with non-zero counts.

// File: rtl/enc_bus_pkg.sv
package enc_bus_pkg;
  typedef enum logic [1:0] {BEAT_CMD = 2'd0, BEAT_WR = 2'd1, BEAT_RD = 2'd2} beat_e;
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_GAP = 2'd1, S_STRB = 2'd2} state_e;
  localparam logic [7:0] OP_LATCH   = 8'h10;
  localparam logic [7:0] OP_PRELOAD = 8'h08;
  localparam logic [7:0] OP_LOAD    = 8'h88;
endpackage

// File: rtl/enc_phase_timer.sv
module enc_phase_timer #(
  parameter int GAP_W  = 2,
  parameter int STRB_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic strb_i,
  output logic end_o
);
  localparam int MAXW = (GAP_W > STRB_W) ? GAP_W : STRB_W;
  localparam int CNTW = $clog2(MAXW + 1);

  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] lim;

  assign lim   = strb_i ? CNTW'(STRB_W - 1) : CNTW'(GAP_W - 1);
  assign end_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!en_i || end_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  // R6
  tmr_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && strb_i) |-> (cnt_q < CNTW'(STRB_W)));
endmodule

// File: rtl/enc_beat_plan.sv
module enc_beat_plan
  import enc_bus_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          wr_i,
  input  logic [2:0]    idx_i,
  input  logic [CW-1:0] wdata_i,
  output beat_e         kind_o,
  output logic [7:0]    byte_o,
  output logic          last_o
);
  localparam int NB = CW / 8;

  logic [CW-1:0] shifted;
  assign shifted = wdata_i >> (8 * (int'(idx_i) - 1));

  always_comb begin
    kind_o = BEAT_CMD;
    byte_o = 8'h00;
    last_o = 1'b0;
    if (wr_i) begin
      if (idx_i == 3'd0) byte_o = OP_PRELOAD;
      else if (int'(idx_i) <= NB) begin
        kind_o = BEAT_WR;
        byte_o = shifted[7:0];
      end else begin
        byte_o = OP_LOAD;
        last_o = 1'b1;
      end
    end else begin
      if (idx_i == 3'd0) byte_o = OP_LATCH;
      else begin
        kind_o = BEAT_RD;
        last_o = (int'(idx_i) == NB);
      end
    end
  end
endmodule

// File: rtl/enc_byte_gather.sv
module enc_byte_gather #(
  parameter int CW = 24,
  parameter int OW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic          publish_i,
  input  logic [7:0]    byte_i,
  output logic [OW-1:0] value_o
);
  logic [CW-1:0] acc_q, acc_nxt;

  // bytes arrive low first, so shift in from the top
  assign acc_nxt = capture_i ? {byte_i, acc_q[CW-1:8]} : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      value_o <= '0;
    end else begin
      acc_q <= acc_nxt;
      if (publish_i) value_o <= {{(OW-CW){acc_nxt[CW-1]}}, acc_nxt};
    end
  end
endmodule

// File: rtl/enc_bus_master.sv
module enc_bus_master
  import enc_bus_pkg::*;
#(
  parameter int GAP_W  = 2,
  parameter int STRB_W = 3,
  parameter int N_AXES = 4,
  parameter int CW     = 24,
  parameter int OW     = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      req_write_i,
  input  logic [$clog2(N_AXES)-1:0] req_axis_i,
  input  logic [CW-1:0]             req_data_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [OW-1:0]             rd_data_o,
  output logic                      bus_cmd_o,
  output logic                      bus_rd_no,
  output logic                      bus_wr_no,
  output logic [$clog2(N_AXES)-1:0] bus_addr_o,
  output logic [7:0]                bus_d_o,
  output logic                      bus_d_oe_o,
  input  logic [7:0]                bus_d_i
);
  localparam int AXW = $clog2(N_AXES);

  state_e        state_q;
  logic [2:0]    beat_q;
  logic [AXW-1:0] axis_q, init_axis_q;
  logic          wr_q, user_q, init_q, done_q;
  logic [CW-1:0] data_q;

  beat_e         kind;
  logic [7:0]    beat_byte;
  logic          last, tmr_end, act, strb_end;

  enc_beat_plan #(.CW(CW)) u_plan (
    .wr_i(wr_q), .idx_i(beat_q), .wdata_i(data_q),
    .kind_o(kind), .byte_o(beat_byte), .last_o(last)
  );

  enc_phase_timer #(.GAP_W(GAP_W), .STRB_W(STRB_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(act),
    .strb_i(state_q == S_STRB), .end_o(tmr_end)
  );

  enc_byte_gather #(.CW(CW), .OW(OW)) u_gather (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .capture_i(strb_end && kind == BEAT_RD),
    .publish_i(strb_end && last && !wr_q),
    .byte_i(bus_d_i), .value_o(rd_data_o)
  );

  assign act      = (state_q != S_IDLE);
  assign strb_end = (state_q == S_STRB) && tmr_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      beat_q      <= '0;
      axis_q      <= '0;
      init_axis_q <= '0;
      wr_q        <= 1'b0;
      user_q      <= 1'b0;
      init_q      <= 1'b1;
      done_q      <= 1'b0;
      data_q      <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          beat_q <= '0;
          if (init_q) begin
            state_q <= S_GAP;
            wr_q    <= 1'b1;
            axis_q  <= init_axis_q;
            data_q  <= '0;
            user_q  <= 1'b0;
          end else if (req_i) begin
            state_q <= S_GAP;
            wr_q    <= req_write_i;
            axis_q  <= req_axis_i;
            data_q  <= req_data_i;
            user_q  <= 1'b1;
          end
        end
        S_GAP: if (tmr_end) state_q <= S_STRB;
        S_STRB: if (tmr_end) begin
          if (last) begin
            state_q <= S_IDLE;
            done_q  <= user_q;
            if (!user_q) begin
              if (init_axis_q == AXW'(N_AXES - 1)) init_q <= 1'b0;
              else init_axis_q <= init_axis_q + 1'b1;
            end
          end else begin
            state_q <= S_GAP;
            beat_q  <= beat_q + 3'd1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = act || init_q;
  assign done_o     = done_q;
  assign bus_addr_o = act ? axis_q : '0;
  assign bus_cmd_o  = act && (kind == BEAT_CMD);
  assign bus_d_oe_o = act && (kind != BEAT_RD);
  assign bus_d_o    = bus_d_oe_o ? beat_byte : 8'h00;
  assign bus_wr_no  = !((state_q == S_STRB) && (kind != BEAT_RD));
  assign bus_rd_no  = !((state_q == S_STRB) && (kind == BEAT_RD));

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!bus_rd_no && !bus_wr_no));
  // R7
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_rd_no) |-> (!bus_d_oe_o && !$past(bus_d_oe_o)));
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (bus_rd_no && bus_wr_no && !bus_d_oe_o && bus_addr_o == '0));
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!bus_rd_no || !bus_wr_no) && $past(!bus_rd_no || !bus_wr_no)) |-> $stable(bus_addr_o));
  // R6
  wr_data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_wr_no && $past(!bus_wr_no)) |-> ($stable(bus_d_o) && $stable(bus_cmd_o)));
endmodule

// File: tb/enc_bus_master_test.sv
module enc_bus_master_test;
  localparam int GAP_W  = 2;
  localparam int STRB_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic        req_i = 1'b0, req_write_i = 1'b0;
  logic [1:0]  req_axis_i = '0;
  logic [23:0] req_data_i = '0;
  logic        busy_o, done_o, bus_cmd_o, bus_rd_no, bus_wr_no, bus_d_oe_o;
  logic [31:0] rd_data_o;
  logic [1:0]  bus_addr_o;
  logic [7:0]  bus_d_o;
  logic [7:0]  bus_d_i = 8'hEE;

  enc_bus_master #(.GAP_W(GAP_W), .STRB_W(STRB_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_write_i(req_write_i),
    .req_axis_i(req_axis_i), .req_data_i(req_data_i), .busy_o(busy_o),
    .done_o(done_o), .rd_data_o(rd_data_o), .bus_cmd_o(bus_cmd_o),
    .bus_rd_no(bus_rd_no), .bus_wr_no(bus_wr_no), .bus_addr_o(bus_addr_o),
    .bus_d_o(bus_d_o), .bus_d_oe_o(bus_d_oe_o), .bus_d_i(bus_d_i)
  );

  int n_cmp = 0, n_bad = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [23:0] ref_cnt[4];
  logic [23:0] dev_cnt[4], dev_pre[4], dev_lat[4];
  int          dev_ptr = 0;
  logic        prev_rd = 1'b1, prev_wr = 1'b1;

  // {rd_check, busy, done, cmd, rd_n, wr_n, addr[1:0], oe, data[7:0]}
  function automatic logic [16:0] tup(bit chk, bit busy, bit done, bit cmd, bit rdn,
                                      bit wrn, logic [1:0] a, bit oe, logic [7:0] d);
    return {chk, busy, done, cmd, rdn, wrn, a, oe, d};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%h exp=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // kind: 0 command, 1 write data, 2 read data
  task automatic push_beat(int kind, logic [7:0] b, logic [1:0] a, string gtag);
    for (int i = 0; i < GAP_W; i++) begin
      exp_q.push_back(tup(0, 1, 0, kind == 0, 1, 1, a, kind != 2, (kind != 2) ? b : 8'h00));
      tag_q.push_back((kind == 2) ? "R7" : gtag);
    end
    for (int i = 0; i < STRB_W; i++) begin
      exp_q.push_back(tup(0, 1, 0, kind == 0, kind != 2, kind == 2, a, kind != 2,
                          (kind != 2) ? b : 8'h00));
      tag_q.push_back("R6");
    end
  endtask

  task automatic push_txn(bit w, logic [1:0] a, logic [23:0] d, string gtag);
    if (w) begin
      push_beat(0, 8'h08, a, gtag);
      push_beat(1, d[7:0], a, gtag);
      push_beat(1, d[15:8], a, gtag);
      push_beat(1, d[23:16], a, gtag);
      push_beat(0, 8'h88, a, gtag);
    end else begin
      push_beat(0, 8'h10, a, gtag);
      for (int i = 0; i < 3; i++) push_beat(2, 8'h00, a, gtag);
    end
  endtask

  task automatic step();
    logic [16:0] e;
    string       t;
    logic [15:0] act;
    @(negedge clk);
    // behavioural counter device
    if (prev_wr && !bus_wr_no) begin
      if (bus_cmd_o) begin
        if (bus_d_o == 8'h10) begin dev_lat[bus_addr_o] = dev_cnt[bus_addr_o]; dev_ptr = 0; end
        else if (bus_d_o == 8'h08) dev_ptr = 0;
        else if (bus_d_o == 8'h88) dev_cnt[bus_addr_o] = dev_pre[bus_addr_o];
      end else if (dev_ptr < 3) begin
        dev_pre[bus_addr_o][dev_ptr*8 +: 8] = bus_d_o;
        dev_ptr++;
      end
    end
    if (prev_rd && !bus_rd_no && dev_ptr < 3) begin
      bus_d_i = dev_lat[bus_addr_o][dev_ptr*8 +: 8];
      dev_ptr++;
    end
    if (bus_rd_no) bus_d_i = 8'hEE;
    prev_rd = bus_rd_no;
    prev_wr = bus_wr_no;
    // reference comparison
    if (exp_q.size() > 0) begin e = exp_q.pop_front(); t = tag_q.pop_front(); end
    else begin e = tup(0, 0, 0, 0, 1, 1, 2'b00, 0, 8'h00); t = "R1"; end
    act = {busy_o, done_o, bus_cmd_o, bus_rd_no, bus_wr_no, bus_addr_o, bus_d_oe_o, bus_d_o};
    check(act == e[15:0], t, "bus tuple", {16'h0, act}, {16'h0, e[15:0]});
    check(!(!bus_rd_no && !bus_wr_no), "R11", "strobe overlap",
          {30'h0, bus_rd_no, bus_wr_no}, 32'h3);
    if (!e[12] || !e[11])
      check(bus_addr_o == e[10:9], "R8", "axis address", {30'h0, bus_addr_o}, {30'h0, e[10:9]});
    if (e[16]) begin
      logic [31:0] x;
      x = rd_exp_q.pop_front();
      t = rd_tag_q.pop_front();
      check(rd_data_o == x, t, "read count", rd_data_o, x);
    end
  endtask

  task automatic issue(bit w, logic [1:0] a, logic [23:0] d, string rtag);
    bit acc;
    acc = (exp_q.size() == 0);
    req_i = 1'b1; req_write_i = w; req_axis_i = a; req_data_i = d;
    if (acc) begin
      push_txn(w, a, d, w ? "R5" : "R3");
      exp_q.push_back(tup(!w, 0, 1, 0, 1, 1, 2'b00, 0, 8'h00));
      tag_q.push_back("R9");
      if (w) ref_cnt[a] = d;
      else begin
        rd_exp_q.push_back({{8{ref_cnt[a][23]}}, ref_cnt[a]});
        rd_tag_q.push_back(rtag);
      end
    end
    step();
    req_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      dev_cnt[i] = 24'h5A5A5A; dev_pre[i] = 24'h0; dev_lat[i] = 24'h0; ref_cnt[i] = 24'h0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state, R2 busy during startup
    check({busy_o, done_o, bus_cmd_o, bus_rd_no, bus_wr_no, bus_addr_o, bus_d_oe_o} == 8'b10011000,
          "R1", "reset outputs",
          {24'h0, busy_o, done_o, bus_cmd_o, bus_rd_no, bus_wr_no, bus_addr_o, bus_d_oe_o},
          32'h98);
    rst_ni = 1'b1;
    // R2 startup clear of all axes
    for (int a = 0; a < 4; a++) begin
      push_txn(1, 2'(a), 24'h0, "R2");
      if (a < 3) begin
        exp_q.push_back(tup(0, 1, 0, 0, 1, 1, 2'b00, 0, 8'h00));
        tag_q.push_back("R2");
      end
    end
    drain();
    step(); step();
    issue(0, 2'd2, 24'h0, "R2"); drain();
    issue(1, 2'd1, 24'h123456, "R5"); drain();
    issue(0, 2'd1, 24'h0, "R4"); drain();
    issue(1, 2'd0, 24'h800001, "R5"); drain();
    issue(0, 2'd0, 24'h0, "R4"); drain();
    issue(1, 2'd3, 24'hFFFFFF, "R5"); drain();
    issue(0, 2'd3, 24'h0, "R4"); drain();
    issue(1, 2'd2, 24'h7FFFFF, "R5"); drain();
    issue(0, 2'd2, 24'h0, "R4"); drain();
    // R10 requests while busy are dropped
    issue(0, 2'd1, 24'h0, "R4");
    step();
    issue(1, 2'd3, 24'h000111, "R10");
    step();
    issue(1, 2'd0, 24'h000222, "R10");
    drain();
    issue(0, 2'd3, 24'h0, "R10"); drain();
    issue(0, 2'd0, 24'h0, "R10"); drain();
    step(); step(); step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule